// File: doc/BRIEF.md
# Low-Frequency Watchdog Timer with NMI Request

This block guards a processor running from a slow oscillator. The oscillator clock goes through a divide-by-`PRESCALE` stage. The ticks from that stage advance a timeout counter. If software fails to restart the timer within `PRESCALE * TIMEOUT_TICKS` oscillator cycles (131072 cycles with the defaults, about four seconds at 32.768 kHz), the block raises a non-maskable interrupt request. That request has top priority (level 4) and its exception vector is 0x000004. The CPU clears the request with an acknowledge pulse.

The timer counts as soon as reset is released. Software can stop it by clearing the enable input. While disabled, the prescaler and the counter are held at zero, so enabling the timer again starts a full timeout period. The timer keeps counting while the CPU is halted, so a halt that runs too long still produces the interrupt. In sleep mode the timer freezes and keeps its progress. All pins are plain level or strobe controls, with no streaming handshake. The only exchange is the request/acknowledge pair: the request stays high until an acknowledge is seen.

Top module: `lf_watchdog_nmi`

## Requirements
- R1: While `rst_ni` is low and on the first sample after it is released, `nmi_req_o` is 0. The timer is enabled from reset: with `wdt_en_i` high it begins counting on the first rising edge after reset release.
- R2: With the timer enabled, not asleep and never restarted, `nmi_req_o` first reads 1 after exactly `PRESCALE * TIMEOUT_TICKS` counting rising edges (edge 1 is the first counting edge), and reads 0 after one edge fewer.
- R3: A `restart_i` pulse sampled at an edge clears both the prescaler and the timeout counter. The next timeout follows a full `PRESCALE * TIMEOUT_TICKS` edges after that edge.
- R4: If `restart_i` is sampled at the same edge at which the timeout would fire, the restart takes effect and no request is raised at that edge.
- R5: While `wdt_en_i` is low, the prescaler and counter are held at zero and no request is raised. After `wdt_en_i` returns high, the timeout again needs a full `PRESCALE * TIMEOUT_TICKS` counting edges.
- R6: `halt_i` has no effect: the timeout occurs at the same edge whether or not halt is asserted.
- R7: While `sleep_i` is high, the prescaler and counter hold their values. The timeout is delayed by exactly the number of edges spent in sleep.
- R8: Once raised, `nmi_req_o` stays 1 until `nmi_ack_i` is sampled high. It reads 0 after that edge.
- R9: After a timeout the counter restarts from zero. Without a restart, the next timeout comes a further `PRESCALE * TIMEOUT_TICKS` edges later.
- R10: If a timeout and `nmi_ack_i` fall on the same edge, the request stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-frequency oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| wdt_en_i | input | 1 | Timer enable; low stops the timer and clears its count |
| restart_i | input | 1 | Software restart strobe, one cycle |
| halt_i | input | 1 | CPU halt indication (timer keeps running) |
| sleep_i | input | 1 | Sleep mode indication (timer frozen) |
| nmi_ack_i | input | 1 | CPU acknowledge, clears the request |
| nmi_req_o | output | 1 | Non-maskable interrupt request, level 4, vector 0x000004 |

## Verification
Two pairs of events can fall on the same edge. The terminal timeout edge can meet a software restart, and it can meet a CPU acknowledge. The bench counts edges from a known start, so that the restart or the acknowledge is sampled exactly on the edge where the timeout fires. In the first case, no request must appear and a full period must follow. In the second case, the request must still read high, and only a later acknowledge may clear it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_PRESCALE_DEF = 128;
  localparam int unsigned WDT_TICKS_DEF    = 1024;
  localparam logic [23:0] WDT_NMI_VECTOR   = 24'h000004;
  localparam int unsigned WDT_NMI_LEVEL    = 4;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESCALE = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sleep_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div_q;
  logic          at_last;

  assign at_last = (div_q == LAST);
  assign tick_o  = en_i && !sleep_i && !restart_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (!en_i || restart_i) begin
      div_q <= '0;
    end else if (!sleep_i) begin
      div_q <= at_last ? '0 : div_q + PW'(1);
    end
  end

  // R7
  sleep_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sleep_i && !restart_i) |=> $stable(div_q));

  // R5
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (div_q == '0));

  // R3
  restart_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (div_q == '0));
endmodule

// File: rtl/wdt_timeout_counter.sv
module wdt_timeout_counter #(
  parameter int unsigned TIMEOUT_TICKS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [CW-1:0] TERM = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == TERM) ? '0 : cnt_q + CW'(1);
    end
  end

  // R3
  restart_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));

  // R9
  wrap_after_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));

  // R2
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TERM);
endmodule

// File: rtl/wdt_nmi_flag.sv
module wdt_nmi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic nmi_o
);
  logic nmi_q;

  assign nmi_o = nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
    end else if (set_i) begin
      nmi_q <= 1'b1;
    end else if (ack_i) begin
      nmi_q <= 1'b0;
    end
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_q && !ack_i) |=> nmi_q);

  // R8
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !nmi_q);

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> nmi_q);
endmodule

// File: rtl/lf_watchdog_nmi.sv
module lf_watchdog_nmi #(
  parameter int unsigned PRESCALE      = wdt_pkg::WDT_PRESCALE_DEF,
  parameter int unsigned TIMEOUT_TICKS = wdt_pkg::WDT_TICKS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_en_i,
  input  logic restart_i,
  input  logic halt_i,
  input  logic sleep_i,
  input  logic nmi_ack_i,
  output logic nmi_req_o
);
  logic tick_w;
  logic expire_w;

  wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wdt_en_i),
    .sleep_i  (sleep_i),
    .restart_i(restart_i),
    .tick_o   (tick_w)
  );

  wdt_timeout_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wdt_en_i),
    .restart_i(restart_i),
    .tick_i   (tick_w),
    .expire_o (expire_w)
  );

  wdt_nmi_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (expire_w),
    .ack_i (nmi_ack_i),
    .nmi_o (nmi_req_o)
  );

  // R4
  restart_beats_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !nmi_req_o) |=> !nmi_req_o);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_en_i && !nmi_req_o) |=> !nmi_req_o);

  // R6
  halt_still_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && expire_w) |=> nmi_req_o);
endmodule

// File: tb/lf_watchdog_nmi_test.sv
module lf_watchdog_nmi_test;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 4;
  localparam int T  = 8;
  localparam int PT = P * T;

  logic clk = 1'b0;
  logic rst_n, en, restart, halt, sleep, ack;
  logic nmi;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lf_watchdog_nmi #(.PRESCALE(P), .TIMEOUT_TICKS(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wdt_en_i(en), .restart_i(restart),
    .halt_i(halt), .sleep_i(sleep), .nmi_ack_i(ack), .nmi_req_o(nmi)
  );

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: nmi_req_o=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b1; restart = 1'b0; halt = 1'b0; sleep = 1'b0; ack = 1'b0;
    run(2);
    check(nmi, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    run(1);
    check(nmi, 1'b0, "R1 after release");
    // one counting edge has now passed
  endtask

  task automatic t_basic();
    do_reset();
    run(PT - 2);
    check(nmi, 1'b0, "R2 one edge early");
    run(1);
    check(nmi, 1'b1, "R2 timeout edge");
  endtask

  task automatic t_restart();
    do_reset();
    run(19);
    restart = 1'b1; run(1); restart = 1'b0;
    run(PT - 1);
    check(nmi, 1'b0, "R3 before full period");
    run(1);
    check(nmi, 1'b1, "R3 full period after restart");
  endtask

  task automatic t_restart_collide();
    do_reset();
    run(PT - 2);
    restart = 1'b1; run(1); restart = 1'b0;
    check(nmi, 1'b0, "R4 restart on terminal edge");
    run(PT - 1);
    check(nmi, 1'b0, "R4 before next period");
    run(1);
    check(nmi, 1'b1, "R4 period after restart");
  endtask

  task automatic t_disable();
    do_reset();
    run(10);
    en = 1'b0;
    run(3 * PT);
    check(nmi, 1'b0, "R5 disabled no request");
    en = 1'b1;
    run(PT - 1);
    check(nmi, 1'b0, "R5 re-enable early");
    run(1);
    check(nmi, 1'b1, "R5 re-enable full period");
  endtask

  task automatic t_halt();
    do_reset();
    halt = 1'b1;
    run(PT - 2);
    check(nmi, 1'b0, "R6 halt early");
    run(1);
    check(nmi, 1'b1, "R6 halt timeout same edge");
    halt = 1'b0;
  endtask

  task automatic t_sleep();
    do_reset();
    run(9);
    sleep = 1'b1;
    run(50);
    check(nmi, 1'b0, "R7 frozen in sleep");
    sleep = 1'b0;
    run(PT - 11);
    check(nmi, 1'b0, "R7 delayed early");
    run(1);
    check(nmi, 1'b1, "R7 delayed timeout");
  endtask

  task automatic t_sticky();
    do_reset();
    run(PT - 1);
    check(nmi, 1'b1, "R8 raised");
    run(5);
    check(nmi, 1'b1, "R8 held without ack");
    ack = 1'b1; run(1); ack = 1'b0;
    check(nmi, 1'b0, "R8 cleared by ack");
  endtask

  task automatic t_rearm();
    do_reset();
    run(PT - 1);
    ack = 1'b1; run(1); ack = 1'b0;
    check(nmi, 1'b0, "R9 acked");
    run(PT - 2);
    check(nmi, 1'b0, "R9 second period early");
    run(1);
    check(nmi, 1'b1, "R9 second timeout");
  endtask

  task automatic t_ack_collide();
    do_reset();
    run(PT - 1);
    run(PT - 1);
    ack = 1'b1; run(1); ack = 1'b0;
    check(nmi, 1'b1, "R10 set beats ack");
    ack = 1'b1; run(1); ack = 1'b0;
    check(nmi, 1'b0, "R10 later ack clears");
  endtask

  initial begin
    t_basic();
    t_restart();
    t_restart_collide();
    t_disable();
    t_halt();
    t_sleep();
    t_sticky();
    t_rearm();
    t_ack_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: bench hung, got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule